// File: doc/BRIEF.md
# Console Keyboard and Display Register Unit

This block sits on the load/store bus of a 16-bit processor. It presents four word-wide registers at fixed addresses: keyboard data, keyboard status, display data and display status. The keyboard side takes a one-cycle valid strobe with an 8-bit character. The display side gives a one-cycle strobe with an 8-bit character and takes back a one-cycle done pulse once the character has been shown.

On a load that hits one of the four addresses, the block steers device data onto the processor's memory data path in place of the RAM word and raises a select line. Each channel has a ready flag and a software-writable interrupt enable, and the two are ANDed to form that channel's request line. When a character is waiting, the keyboard ignores new keystrokes until software reads the character. The display drops any write made while it is busy.

Top module: `console_io_regs`

## Requirements
- R1: A load (`bus_rd`=1) at 0xFE00, 0xFE02, 0xFE04 or 0xFE06 raises `dev_sel` and drives `mdr_data` from that device register in the same cycle. Every other cycle, `dev_sel` is 0 and `mdr_data` equals `mem_rdata`. A load at 0xFE06 returns the last character accepted for display in bits [7:0], with zeros above.
- R2: A `kbd_valid` strobe while the keyboard ready flag is 0 latches `kbd_char` and sets the flag. Keyboard data (0xFE02) then reads {8'h00, char}.
- R3: While the keyboard ready flag is 1, further `kbd_valid` strobes are discarded and the latched character is kept.
- R4: A load at 0xFE02 clears the keyboard ready flag from the next cycle on. A keyboard strobe in that same cycle is dropped.
- R5: A store at 0xFE06 while the display ready flag is 1 clears that flag. In the next cycle it gives a one-cycle `disp_strobe` with `disp_char` equal to store data bits [7:0].
- R6: A store at 0xFE06 while the display ready flag is 0 is ignored: no strobe, and `disp_char` is unchanged.
- R7: A `disp_done` pulse while the display ready flag is 0 sets the flag, so that it reads 1 from the next cycle on. A `disp_done` pulse while the flag is already 1 has no effect.
- R8: Status words read as {ready, enable, 14'b0}, with ready in bit 15 and enable in bit 14. A store to a status address changes only bit 14. Bit 15 is read-only.
- R9: `kbd_irq` equals the keyboard ready flag AND the keyboard enable, and `disp_irq` equals the display ready flag AND the display enable.
- R10: After reset, the display ready flag is 1, and the keyboard ready flag and both enables are 0. Display status therefore reads 16'h8000 and keyboard status reads 16'h0000.
- R11: Stores to addresses other than the four decoded ones change no device register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Load/store word address |
| bus_rd | input | 1 | Load in this cycle |
| bus_wr | input | 1 | Store in this cycle |
| bus_wdata | input | 16 | Store data |
| mem_rdata | input | 16 | Read data from RAM |
| mdr_data | output | 16 | Data for the memory data register |
| dev_sel | output | 1 | A device register is being read |
| kbd_valid | input | 1 | Keyboard character strobe |
| kbd_char | input | 8 | Keyboard character code |
| disp_strobe | output | 1 | Display character strobe |
| disp_char | output | 8 | Character to display |
| disp_done | input | 1 | Display finished pulse |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
Random bus traffic is spread over the four decoded addresses and over arbitrary other addresses, with keystrokes and done pulses at random densities. This shows whether decoding, the ready handshakes and the enable bits stay consistent when they interleave. Directed sequences separate the cases that random traffic seldom lines up. A second keystroke is sent while a character is still waiting, which tells lockout apart from overwrite. A data read is made in the same cycle as a keystroke, which tells drop apart from capture. A display write is made while the display is busy, which tells discard apart from queueing. Status stores with every bit set show that bit 15 and the low bits are not writable.

// File: rtl/console_pkg.sv
// Shared constants and types for the console register unit.
// Assumes word addressing on a 16-bit bus.
package console_pkg;
    localparam int WORD_W    = 16;
    localparam int CHAR_W    = 8;
    localparam int READY_BIT = 15;
    localparam int IE_BIT    = 14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KSTAT,
        SEL_KDATA,
        SEL_DSTAT,
        SEL_DDATA
    } reg_sel_e;
endpackage

// File: rtl/con_addr_decode.sv
// Address decoder: maps a bus address to one of four device registers.
// Assumes at most one of rd/wr is active in a cycle.
module con_addr_decode
    import console_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
    parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
    parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
    parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output reg_sel_e          sel,
    output logic              rd_hit,
    output logic              rd_kdata,
    output logic              wr_kstat,
    output logic              wr_dstat,
    output logic              wr_ddata
);
    // Match the address against the four fixed locations.
    always_comb begin
        if (addr == KSTAT_ADDR)      sel = SEL_KSTAT;
        else if (addr == KDATA_ADDR) sel = SEL_KDATA;
        else if (addr == DSTAT_ADDR) sel = SEL_DSTAT;
        else if (addr == DDATA_ADDR) sel = SEL_DDATA;
        else                         sel = SEL_NONE;
    end

    // Qualify the match with the access type.
    always_comb begin
        rd_hit   = rd && (sel != SEL_NONE);
        rd_kdata = rd && (sel == SEL_KDATA);
        wr_kstat = wr && (sel == SEL_KSTAT);
        wr_dstat = wr && (sel == SEL_DSTAT);
        wr_ddata = wr && (sel == SEL_DDATA);
    end
endmodule

// File: rtl/con_kbd_chan.sv
// Keyboard channel: latches one character and holds it until it is read.
// Assumes key_valid is a one-cycle strobe. Strobes that arrive while a
// character is waiting, or in the cycle of a data read, are discarded.
module con_kbd_chan #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              data_read,
    input  logic              ie_wr,
    input  logic              ie_wdata,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] data
);
    // Ready flag and character latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            data  <= '0;
        end else if (data_read) begin
            ready <= 1'b0;
        end else if (key_valid && !ready) begin
            ready <= 1'b1;
            data  <= key_char;
        end
    end

    // Interrupt enable bit, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= 1'b0;
        else if (ie_wr) ie <= ie_wdata;
    end
endmodule

// File: rtl/con_disp_chan.sv
// Display channel: accepts one character at a time and drops writes
// made while busy. The strobe and character are registered and appear
// one cycle after the accepted write. Assumes done is a one-cycle pulse.
module con_disp_chan #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              ie_wr,
    input  logic              ie_wdata,
    input  logic              done,
    output logic              ready,
    output logic              ie,
    output logic              strobe,
    output logic [CHAR_W-1:0] char_out
);
    logic accept;

    // A write is taken only while the display is ready.
    always_comb accept = char_wr && ready;

    // Ready flag: cleared on an accepted write, set again by done.
    always_ff @(posedge clk) begin
        if (!rst_n)              ready <= 1'b1;
        else if (accept)         ready <= 1'b0;
        else if (done && !ready) ready <= 1'b1;
    end

    // Output strobe and held character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe   <= 1'b0;
            char_out <= '0;
        end else begin
            strobe <= accept;
            if (accept) char_out <= wchar;
        end
    end

    // Interrupt enable bit, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= 1'b0;
        else if (ie_wr) ie <= ie_wdata;
    end
endmodule

// File: rtl/console_io_regs.sv
// Memory-mapped console register unit. It decodes four word addresses,
// steers device data into the memory data path on loads, and runs the
// keyboard and display ready handshakes. Assumes a synchronous bus
// with single-cycle accesses.
module console_io_regs
    import console_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
    parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
    parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
    parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic [WORD_W-1:0]   mdr_data,
    output logic                dev_sel,
    input  logic                kbd_valid,
    input  logic [CHAR_W-1:0]   kbd_char,
    output logic                disp_strobe,
    output logic [CHAR_W-1:0]   disp_char,
    input  logic                disp_done,
    output logic                kbd_irq,
    output logic                disp_irq
);
    localparam int PAD_W = WORD_W - CHAR_W;

    reg_sel_e          sel;
    logic              rd_hit, rd_kdata, wr_kstat, wr_dstat, wr_ddata;
    logic              kbd_ready, kbd_ie, disp_ready, disp_ie;
    logic [CHAR_W-1:0] kbd_data;
    logic [WORD_W-1:0] dev_rdata;

    con_addr_decode #(
        .ADDR_W(ADDR_W), .KSTAT_ADDR(KSTAT_ADDR), .KDATA_ADDR(KDATA_ADDR),
        .DSTAT_ADDR(DSTAT_ADDR), .DDATA_ADDR(DDATA_ADDR)
    ) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .sel(sel),
        .rd_hit(rd_hit), .rd_kdata(rd_kdata), .wr_kstat(wr_kstat),
        .wr_dstat(wr_dstat), .wr_ddata(wr_ddata)
    );

    con_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
        .clk(clk), .rst_n(rst_n), .key_valid(kbd_valid), .key_char(kbd_char),
        .data_read(rd_kdata), .ie_wr(wr_kstat), .ie_wdata(bus_wdata[IE_BIT]),
        .ready(kbd_ready), .ie(kbd_ie), .data(kbd_data)
    );

    con_disp_chan #(.CHAR_W(CHAR_W)) u_disp (
        .clk(clk), .rst_n(rst_n), .char_wr(wr_ddata),
        .wchar(bus_wdata[CHAR_W-1:0]), .ie_wr(wr_dstat),
        .ie_wdata(bus_wdata[IE_BIT]), .done(disp_done),
        .ready(disp_ready), .ie(disp_ie), .strobe(disp_strobe),
        .char_out(disp_char)
    );

    // Assemble the device register word selected by the decoder.
    always_comb begin
        dev_rdata = '0;
        case (sel)
            SEL_KSTAT: begin
                dev_rdata[READY_BIT] = kbd_ready;
                dev_rdata[IE_BIT]    = kbd_ie;
            end
            SEL_KDATA: dev_rdata = {{PAD_W{1'b0}}, kbd_data};
            SEL_DSTAT: begin
                dev_rdata[READY_BIT] = disp_ready;
                dev_rdata[IE_BIT]    = disp_ie;
            end
            SEL_DDATA: dev_rdata = {{PAD_W{1'b0}}, disp_char};
            default:   dev_rdata = '0;
        endcase
    end

    // Steer memory data or device data to the data register.
    always_comb begin
        dev_sel  = rd_hit;
        mdr_data = rd_hit ? dev_rdata : mem_rdata;
    end

    // Interrupt requests: ready AND enable per channel.
    always_comb begin
        kbd_irq  = kbd_ready && kbd_ie;
        disp_irq = disp_ready && disp_ie;
    end
endmodule

// File: rtl/con_io_checker.sv
// Assertion checker for console_io_regs, attached with bind.
module con_io_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [15:0] bus_wdata,
    input logic [15:0] mem_rdata,
    input logic [15:0] mdr_data,
    input logic        dev_sel,
    input logic        kbd_valid,
    input logic        disp_strobe,
    input logic [7:0]  disp_char,
    input logic        disp_done,
    input logic        kbd_irq,
    input logic        kbd_ready,
    input logic [7:0]  kbd_data,
    input logic        disp_ready
);
    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_sel |-> mdr_data == mem_rdata);

    assert_kstat_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel && bus_addr == 16'hFE00) |-> kbd_irq == (mdr_data[15] && mdr_data[14]));

    assert_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_ready && kbd_valid) |=> $stable(kbd_data));

    assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 16'hFE02) |=> !kbd_ready);

    assert_disp_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 16'hFE06 && disp_ready)
        |=> (disp_strobe && disp_char == $past(bus_wdata[7:0]) && !disp_ready));

    assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 16'hFE06 && !disp_ready) |=> (!disp_strobe && $stable(disp_char)));

    assert_done_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_done && !disp_ready) |=> disp_ready);
endmodule

bind console_io_regs con_io_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mem_rdata(mem_rdata),
    .mdr_data(mdr_data), .dev_sel(dev_sel), .kbd_valid(kbd_valid),
    .disp_strobe(disp_strobe), .disp_char(disp_char), .disp_done(disp_done),
    .kbd_irq(kbd_irq), .kbd_ready(kbd_ready), .kbd_data(kbd_data),
    .disp_ready(disp_ready)
);

// File: tb/tb_console_io_regs.sv
module tb_console_io_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0, mem_rdata = '0, mdr_data;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, dev_sel;
    logic        kbd_valid = 1'b0, disp_done = 1'b0;
    logic [7:0]  kbd_char = '0, disp_char;
    logic        disp_strobe, kbd_irq, disp_irq;

    int checks = 0, failures = 0;
    logic        m_kr, m_ki, m_dr, m_di, m_strobe;
    logic [7:0]  m_kd, m_dc;
    logic [15:0] last_mdr;

    always #10 clk = ~clk;

    console_io_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mem_rdata(mem_rdata),
        .mdr_data(mdr_data), .dev_sel(dev_sel), .kbd_valid(kbd_valid),
        .kbd_char(kbd_char), .disp_strobe(disp_strobe), .disp_char(disp_char),
        .disp_done(disp_done), .kbd_irq(kbd_irq), .disp_irq(disp_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected load data from the requirements.
    function automatic logic [15:0] exp_read(input logic rd, input logic [15:0] a,
                                             input logic [15:0] mem);
        if (!rd) return mem;
        case (a)
            16'hFE00: return {m_kr, m_ki, 14'b0};
            16'hFE02: return {8'h00, m_kd};
            16'hFE04: return {m_dr, m_di, 14'b0};
            16'hFE06: return {8'h00, m_dc};
            default:  return mem;
        endcase
    endfunction

    function automatic string tag_for(input logic [15:0] a);
        case (a)
            16'hFE00, 16'hFE04: return "R8";
            16'hFE02:           return "R2";
            default:            return "R1";
        endcase
    endfunction

    // One bus cycle with model update and checks.
    task automatic step(input logic rd, input logic wr, input logic [15:0] a,
                        input logic [15:0] wd, input logic kv, input logic [7:0] kc,
                        input logic dn);
        logic hit;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        kbd_valid = kv; kbd_char = kc; disp_done = dn;
        mem_rdata = 16'($urandom);
        #2;
        hit = rd && (a == 16'hFE00 || a == 16'hFE02 || a == 16'hFE04 || a == 16'hFE06);
        last_mdr = mdr_data;
        chk(tag_for(a), mdr_data, exp_read(rd, a, mem_rdata));
        chk("R1", {15'b0, dev_sel}, {15'b0, hit});
        @(posedge clk);
        // model update with pre-edge inputs
        if (rd && a == 16'hFE02) m_kr = 1'b0;
        else if (kv && !m_kr) begin m_kr = 1'b1; m_kd = kc; end
        if (wr && a == 16'hFE00) m_ki = wd[14];
        if (wr && a == 16'hFE04) m_di = wd[14];
        m_strobe = 1'b0;
        if (wr && a == 16'hFE06 && m_dr) begin m_dr = 1'b0; m_strobe = 1'b1; m_dc = wd[7:0]; end
        else if (dn && !m_dr) m_dr = 1'b1;
        #2;
        chk("R5", {15'b0, disp_strobe}, {15'b0, m_strobe});
        chk("R6", {8'b0, disp_char}, {8'b0, m_dc});
        chk("R9", {14'b0, kbd_irq, disp_irq}, {14'b0, m_kr && m_ki, m_dr && m_di});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        m_kr = 0; m_ki = 0; m_dr = 1; m_di = 0; m_kd = 0; m_dc = 0; m_strobe = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10 reset state
        step(1, 0, 16'hFE04, 0, 0, 0, 0); chk("R10", last_mdr, 16'h8000);
        step(1, 0, 16'hFE00, 0, 0, 0, 0); chk("R10", last_mdr, 16'h0000);
        chk("R10", {14'b0, kbd_irq, disp_irq}, 16'h0000);

        // R2 capture, R3 lockout
        step(0, 0, 16'h0000, 0, 1, 8'h41, 0);
        step(1, 0, 16'hFE00, 0, 1, 8'h42, 0); chk("R2", last_mdr, 16'h8000);
        step(1, 0, 16'hFE02, 0, 0, 0, 0);     chk("R3", last_mdr, 16'h0041);
        step(1, 0, 16'hFE00, 0, 0, 0, 0);     chk("R4", last_mdr, 16'h0000);

        // R4 same-cycle read and keystroke
        step(0, 0, 16'h0000, 0, 1, 8'h55, 0);
        step(1, 0, 16'hFE02, 0, 1, 8'h66, 0); chk("R4", last_mdr, 16'h0055);
        step(1, 0, 16'hFE00, 0, 0, 0, 0);     chk("R4", last_mdr, 16'h0000);

        // R8 status writes touch only bit 14; R9 irq
        step(0, 1, 16'hFE00, 16'hFFFF, 0, 0, 0);
        step(1, 0, 16'hFE00, 0, 0, 0, 0);     chk("R8", last_mdr, 16'h4000);
        step(0, 0, 16'h0000, 0, 1, 8'h7A, 0); chk("R9", {15'b0, kbd_irq}, 16'h0001);
        step(0, 1, 16'hFE04, 16'hFFFF, 0, 0, 0);
        step(1, 0, 16'hFE04, 0, 0, 0, 0);     chk("R8", last_mdr, 16'hC000);
        chk("R9", {15'b0, disp_irq}, 16'h0001);

        // R11 stray stores change nothing
        step(0, 1, 16'hFE01, 16'h0000, 0, 0, 0);
        step(0, 1, 16'hFE08, 16'h0000, 0, 0, 0);
        step(1, 0, 16'hFE04, 0, 0, 0, 0);     chk("R11", last_mdr, 16'hC000);
        step(1, 0, 16'hFE00, 0, 0, 0, 0);     chk("R11", last_mdr, 16'hC000);

        // R5 send, R6 busy drop, R7 done
        step(0, 1, 16'hFE06, 16'h1234, 0, 0, 0);
        chk("R5", {8'b0, disp_char}, 16'h0034);
        step(0, 1, 16'hFE06, 16'h0099, 0, 0, 0);
        chk("R6", {7'b0, disp_strobe, disp_char}, 16'h0034);
        step(1, 0, 16'hFE04, 0, 0, 0, 0);     chk("R7", last_mdr, 16'h4000);
        step(0, 0, 16'h0000, 0, 0, 0, 1);
        step(1, 0, 16'hFE04, 0, 0, 0, 1);     chk("R7", last_mdr, 16'hC000);
        step(1, 0, 16'hFE06, 0, 0, 0, 0);     chk("R1", last_mdr, 16'h0034);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            logic [2:0]  pick;
            logic [1:0]  op;
            pick = 3'($urandom_range(0, 5));
            case (pick)
                3'd0: a = 16'hFE00;
                3'd1: a = 16'hFE02;
                3'd2: a = 16'hFE04;
                3'd3: a = 16'hFE06;
                default: a = 16'($urandom);
            endcase
            op = 2'($urandom_range(0, 2));
            step(op == 2'd1, op == 2'd2, a, 16'($urandom),
                 ($urandom_range(0, 9) < 3), 8'($urandom),
                 ($urandom_range(0, 9) < 2));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule